// File: doc/BRIEF.md
# Chip-Select Region Decoder

The block sorts each external bus cycle into one of ten programmable address regions. Eight regions drive individual active-low chip selects and two regions select DRAM blocks. Each region holds a base address, a don't-care mask, a valid bit and three attributes: the external port width, whether bursts are allowed, and whether the cycle is terminated internally. When a cycle starts, the block compares the address against every region in parallel. It then produces the chip selects, a one-hot DRAM select, active-low byte strobes for the data lanes in use, an active-low output enable for reads, and the cycle's attributes. Software loads the regions through a one-region-per-write configuration port.

The block has two states. In `ST_IDLE` all outputs are deasserted. The START transition (`ST_IDLE` to `ST_ACTIVE`) happens on a falling clock edge where `cyc_start` is high, and it captures the decoded result. In `ST_ACTIVE` the outputs hold steady (the HOLD self-loop) until a falling edge sees `cyc_end` high. The FINISH transition (`ST_ACTIVE` to `ST_IDLE`) then deasserts everything. In `ST_IDLE` with `cyc_start` low, the block stays put (the WAIT self-loop). Because outputs are registered on the falling edge, they change only while the bus clock is low.

Corner cases have fixed rules. A cycle that hits nothing becomes a default cycle. A cycle that hits several chip-select regions drives all of those selects with default attributes. A DRAM region overlapping anything else raises `conflict` and selects nothing.

Top module: `csel_decoder`

## Requirements
- R1: A region hits when its valid bit is 1 and the captured address equals its base on every bit whose mask bit is 0; a mask bit of 1 makes that address bit don't-care; a region with valid 0 never hits.
- R2: When exactly one chip-select region i (cfg_sel 0..7) hits and no DRAM region does, only cs_n[i] is low. attr_psize is that region's width code. attr_burst_inh is the inverse of its burst enable. attr_ext_term is the inverse of its internal-termination bit.
- R3: When exactly one DRAM region j (cfg_sel 8+j) hits and no chip-select region does, dram_sel is one-hot at bit j, cs_n is all ones, and the attributes come from that DRAM region as in R2.
- R4: When no region hits, cs_n is all ones, dram_sel is 0, attr_psize is 2'b00 (32-bit), and attr_burst_inh and attr_ext_term are both 1.
- R5: When two or more chip-select regions hit and no DRAM region does, every hitting chip select is low, and the attributes are forced to 2'b00, burst inhibited and externally terminated.
- R6: When both DRAM regions hit, or a DRAM region and any chip-select region hit, conflict is 1. In that case cs_n, bs_n and oe_n are all ones, dram_sel is 0, and the attributes take the default values of R4.
- R7: On a 32-bit port (width code 2'b00), byte offset n (addr[1:0]) uses lane strobe bs_n[3-n]. A 16-bit access (cyc_size 2'b01) strobes bs_n[3:2] when addr[1] is 0 and bs_n[1:0] when addr[1] is 1. A 32-bit access (cyc_size 2'b10 or 2'b11) strobes all four lanes. A byte access is cyc_size 2'b00.
- R8: On a 16-bit port (code 2'b10), a byte access strobes bs_n[3] when addr[0] is 0 and bs_n[2] when addr[0] is 1; wider accesses strobe bs_n[3:2]. On an 8-bit port (code 2'b01), every access strobes bs_n[3] only. The unused strobes stay high.
- R9: oe_n is low during a cycle exactly when the cycle was started as a read (cyc_rd 1) and is not a conflict.
- R10: The START transition happens on the falling edge where cyc_start is high in ST_IDLE and loads the decode of the address, direction and size present then. Those outputs then hold unchanged through ST_ACTIVE whatever the bus inputs do, until the falling edge where cyc_end is high (the FINISH transition).
- R11: After reset and in ST_IDLE, cs_n and bs_n are all ones, oe_n is 1, dram_sel is 0, conflict is 0, attr_psize is 2'b00, and attr_burst_inh and attr_ext_term are 0. cyc_end in ST_IDLE and cyc_start in ST_ACTIVE have no effect.
- R12: A write (cfg_we high on a rising edge) replaces all fields of region cfg_sel and leaves the others alone. A write with cfg_sel of 10 or more is discarded. Width code 2'b11 is treated as 32-bit, and attr_psize then reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; config on rising edge, outputs on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_sel | input | 4 | Region index: 0..7 chip selects, 8..9 DRAM |
| cfg_base | input | 32 | Region base address |
| cfg_mask | input | 32 | Don't-care mask, 1 = ignore bit |
| cfg_valid | input | 1 | Region takes part in matching |
| cfg_psize | input | 2 | Port width code: 00 32-bit, 01 8-bit, 10 16-bit, 11 as 32-bit |
| cfg_burst_en | input | 1 | Region allows bursts |
| cfg_int_term | input | 1 | Region is terminated internally |
| cyc_start | input | 1 | Start of a bus cycle |
| cyc_end | input | 1 | End of the current bus cycle |
| cyc_addr | input | 32 | Cycle address |
| cyc_rd | input | 1 | 1 = read, 0 = write |
| cyc_size | input | 2 | Access size: 00 byte, 01 16-bit, 1x 32-bit |
| cs_n | output | 8 | Active-low chip selects |
| dram_sel | output | 2 | One-hot DRAM block select |
| bs_n | output | 4 | Active-low byte strobes, bs_n[3] for D[31:24] |
| oe_n | output | 1 | Active-low output enable |
| attr_psize | output | 2 | Port width of the cycle |
| attr_burst_inh | output | 1 | Burst inhibited |
| attr_ext_term | output | 1 | Externally terminated |
| conflict | output | 1 | DRAM overlap fault |

## Verification
Every decoded output appears after the first falling edge that follows the rising edge on which the bench raises `cyc_start`. That is half a clock later. The idle values return after the falling edge that sees `cyc_end`. The scoreboard monitor samples one nanosecond after each of those falling edges. It compares one queued expectation per falling edge while the cycle is active: the first right after START, and a second one after the bench has scrambled the address and direction and re-pulsed `cyc_start`. That second sample shows the hold behaviour. Configuration writes land on a rising edge and are always completed a full cycle before the next bus cycle starts.

// File: rtl/csd_pkg.sv
package csd_pkg;

    typedef enum logic [1:0] {
        PS_32  = 2'b00,
        PS_8   = 2'b01,
        PS_16  = 2'b10,
        PS_RSV = 2'b11
    } psize_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } state_e;

    typedef struct packed {
        psize_e psize;
        logic   burst_en;
        logic   int_term;
    } rattr_t;

endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_REG  = 10,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] mask_in,
    input  logic              valid_in,
    input  rattr_t            attr_in,
    output logic [ADDR_W-1:0] base_q  [N_REG],
    output logic [ADDR_W-1:0] mask_q  [N_REG],
    output logic              valid_q [N_REG],
    output rattr_t            attr_q  [N_REG]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REG; i++) begin
                base_q[i]  <= '0;
                mask_q[i]  <= '0;
                valid_q[i] <= 1'b0;
                attr_q[i]  <= '{psize: PS_32, burst_en: 1'b0, int_term: 1'b0};
            end
        end else if (we) begin
            for (int i = 0; i < N_REG; i++) begin
                if (sel == SEL_W'(i)) begin
                    base_q[i]  <= base_in;
                    mask_q[i]  <= mask_in;
                    valid_q[i] <= valid_in;
                    attr_q[i]  <= attr_in;
                end
            end
        end
    end

endmodule

// File: rtl/csd_region_match.sv
module csd_region_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic              valid,
    output logic              hit
);

    always_comb begin
        hit = valid && (((addr ^ base) & ~mask) == '0);
    end

endmodule

// File: rtl/csd_lane_map.sv
module csd_lane_map
    import csd_pkg::*;
(
    input  psize_e      psize,
    input  logic [1:0]  a_lo,
    input  logic [1:0]  xsize,
    output logic [3:0]  lanes
);

    always_comb begin
        unique case (psize)
            PS_8:  lanes = 4'b1000;
            PS_16: begin
                if (xsize == 2'b00) lanes = a_lo[0] ? 4'b0100 : 4'b1000;
                else                lanes = 4'b1100;
            end
            default: begin
                unique case (xsize)
                    2'b00:   lanes = 4'b1000 >> a_lo;
                    2'b01:   lanes = a_lo[1] ? 4'b0011 : 4'b1100;
                    default: lanes = 4'b1111;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
    import csd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_CS   = 8,
    parameter int N_DR   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(N_CS+N_DR)-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0]             cfg_base,
    input  logic [ADDR_W-1:0]             cfg_mask,
    input  logic                          cfg_valid,
    input  logic [1:0]                    cfg_psize,
    input  logic                          cfg_burst_en,
    input  logic                          cfg_int_term,
    input  logic                          cyc_start,
    input  logic                          cyc_end,
    input  logic [ADDR_W-1:0]             cyc_addr,
    input  logic                          cyc_rd,
    input  logic [1:0]                    cyc_size,
    output logic [N_CS-1:0]               cs_n,
    output logic [N_DR-1:0]               dram_sel,
    output logic [3:0]                    bs_n,
    output logic                          oe_n,
    output logic [1:0]                    attr_psize,
    output logic                          attr_burst_inh,
    output logic                          attr_ext_term,
    output logic                          conflict
);

    localparam int N_REG = N_CS + N_DR;
    localparam int SEL_W = $clog2(N_REG);

    // configuration storage
    rattr_t            cfg_attr_in;
    logic [ADDR_W-1:0] base_q  [N_REG];
    logic [ADDR_W-1:0] mask_q  [N_REG];
    logic              valid_q [N_REG];
    rattr_t            attr_q  [N_REG];

    always_comb begin
        cfg_attr_in = '{psize: psize_e'(cfg_psize), burst_en: cfg_burst_en, int_term: cfg_int_term};
    end

    csd_cfg_regs #(.ADDR_W(ADDR_W), .N_REG(N_REG), .SEL_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .base_in  (cfg_base),
        .mask_in  (cfg_mask),
        .valid_in (cfg_valid),
        .attr_in  (cfg_attr_in),
        .base_q   (base_q),
        .mask_q   (mask_q),
        .valid_q  (valid_q),
        .attr_q   (attr_q)
    );

    // parallel region compare
    logic [N_REG-1:0] hit;

    generate
        for (genvar g = 0; g < N_REG; g++) begin : g_match
            csd_region_match #(.ADDR_W(ADDR_W)) u_match (
                .addr  (cyc_addr),
                .base  (base_q[g]),
                .mask  (mask_q[g]),
                .valid (valid_q[g]),
                .hit   (hit[g])
            );
        end
    endgenerate

    logic [N_CS-1:0] cs_hit;
    logic [N_DR-1:0] dr_hit;
    assign cs_hit = hit[N_CS-1:0];
    assign dr_hit = hit[N_REG-1:N_CS];

    // hit resolution
    int        n_cs;
    int        n_dr;
    rattr_t    pick;
    logic      one_hit;
    logic      d_conf;
    psize_e    d_ps;
    logic      d_binh;
    logic      d_eterm;
    logic [N_CS-1:0] d_cs_n;
    logic [N_DR-1:0] d_dram;

    always_comb begin
        n_cs = $countones(cs_hit);
        n_dr = $countones(dr_hit);
        pick = attr_q[0];
        for (int i = 0; i < N_REG; i++) begin
            if (hit[i]) pick = attr_q[i];
        end
        d_conf  = (n_dr > 1) || (n_dr == 1 && n_cs > 0);
        one_hit = !d_conf && ((n_cs + n_dr) == 1);
        if (one_hit) begin
            d_ps    = (pick.psize == PS_RSV) ? PS_32 : pick.psize;
            d_binh  = ~pick.burst_en;
            d_eterm = ~pick.int_term;
        end else begin
            d_ps    = PS_32;
            d_binh  = 1'b1;
            d_eterm = 1'b1;
        end
        d_cs_n = d_conf ? '1 : ~cs_hit;
        d_dram = d_conf ? '0 : dr_hit;
    end

    logic [3:0] lanes;

    csd_lane_map u_lanes (
        .psize (d_ps),
        .a_lo  (cyc_addr[1:0]),
        .xsize (cyc_size),
        .lanes (lanes)
    );

    logic [3:0] d_bs_n;
    logic       d_oe_n;

    always_comb begin
        d_bs_n = d_conf ? 4'b1111 : ~lanes;
        d_oe_n = d_conf ? 1'b1 : ~cyc_rd;
    end

    // cycle state machine
    state_e state_q, state_d;
    logic   busy;
    logic   go;
    logic   done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cyc_start) state_d = ST_ACTIVE;
            ST_ACTIVE: if (cyc_end)   state_d = ST_IDLE;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy = (state_q == ST_ACTIVE);
    assign go   = (state_q == ST_IDLE) && cyc_start;
    assign done = busy && cyc_end;

    // low-phase output register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n           <= '1;
            dram_sel       <= '0;
            bs_n           <= 4'b1111;
            oe_n           <= 1'b1;
            attr_psize     <= 2'b00;
            attr_burst_inh <= 1'b0;
            attr_ext_term  <= 1'b0;
            conflict       <= 1'b0;
        end else if (go) begin
            cs_n           <= d_cs_n;
            dram_sel       <= d_dram;
            bs_n           <= d_bs_n;
            oe_n           <= d_oe_n;
            attr_psize     <= d_ps;
            attr_burst_inh <= d_binh;
            attr_ext_term  <= d_eterm;
            conflict       <= d_conf;
        end else if (done) begin
            cs_n           <= '1;
            dram_sel       <= '0;
            bs_n           <= 4'b1111;
            oe_n           <= 1'b1;
            attr_psize     <= 2'b00;
            attr_burst_inh <= 1'b0;
            attr_ext_term  <= 1'b0;
            conflict       <= 1'b0;
        end
    end

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int N_CS = 8,
    parameter int N_DR = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic [N_CS-1:0] cs_n,
    input logic [N_DR-1:0] dram_sel,
    input logic [3:0]      bs_n,
    input logic            oe_n,
    input logic [1:0]      attr_psize,
    input logic            attr_burst_inh,
    input logic            attr_ext_term,
    input logic            conflict
);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n == '1 && dram_sel == '0 && bs_n == 4'hF && oe_n && !conflict));

    // R6
    conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (cs_n == '1 && dram_sel == '0 && bs_n == 4'hF && oe_n));

    // R3
    dram_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dram_sel));

    // R5
    multi_cs_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~cs_n) > 1) |-> (attr_psize == 2'b00 && attr_burst_inh && attr_ext_term));

    // R8
    narrow8_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_psize == 2'b01) |-> (bs_n[2:0] == 3'b111));

    // R8
    narrow16_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_psize == 2'b10) |-> (bs_n[1:0] == 2'b11));

    // R9
    oe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> busy);

    // R10
    hold_during_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cs_n) && $stable(bs_n) && $stable(oe_n) && $stable(dram_sel)));

endmodule

bind csel_decoder csd_checker #(.N_CS(N_CS), .N_DR(N_DR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .cs_n           (cs_n),
    .dram_sel       (dram_sel),
    .bs_n           (bs_n),
    .oe_n           (oe_n),
    .attr_psize     (attr_psize),
    .attr_burst_inh (attr_burst_inh),
    .attr_ext_term  (attr_ext_term),
    .conflict       (conflict)
);

// File: tb/csel_decoder_tb.sv
`timescale 1ns/1ps
module csel_decoder_tb;

    localparam int NR = 10;

    typedef struct {
        logic [7:0] cs_n;
        logic [1:0] dram;
        logic [3:0] bs_n;
        logic       oe_n;
        logic [1:0] ps;
        logic       binh;
        logic       eterm;
        logic       conf;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_mask = '0;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_psize = '0;
    logic        cfg_burst_en = 1'b0;
    logic        cfg_int_term = 1'b0;
    logic        cyc_start = 1'b0;
    logic        cyc_end = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_rd = 1'b0;
    logic [1:0]  cyc_size = '0;
    logic [7:0]  cs_n;
    logic [1:0]  dram_sel;
    logic [3:0]  bs_n;
    logic        oe_n;
    logic [1:0]  attr_psize;
    logic        attr_burst_inh;
    logic        attr_ext_term;
    logic        conflict;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] sh_base [NR];
    logic [31:0] sh_mask [NR];
    logic        sh_valid[NR];
    logic [1:0]  sh_ps   [NR];
    logic        sh_bur  [NR];
    logic        sh_it   [NR];

    exp_t q[$];

    always #4 clk = ~clk;

    csel_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_valid(cfg_valid), .cfg_psize(cfg_psize), .cfg_burst_en(cfg_burst_en),
        .cfg_int_term(cfg_int_term),
        .cyc_start(cyc_start), .cyc_end(cyc_end), .cyc_addr(cyc_addr),
        .cyc_rd(cyc_rd), .cyc_size(cyc_size),
        .cs_n(cs_n), .dram_sel(dram_sel), .bs_n(bs_n), .oe_n(oe_n),
        .attr_psize(attr_psize), .attr_burst_inh(attr_burst_inh),
        .attr_ext_term(attr_ext_term), .conflict(conflict)
    );

    function automatic exp_t idle_exp(string tag);
        exp_t e;
        e.cs_n = 8'hFF; e.dram = 2'b00; e.bs_n = 4'hF; e.oe_n = 1'b1;
        e.ps = 2'b00; e.binh = 1'b0; e.eterm = 1'b0; e.conf = 1'b0; e.tag = tag;
        return e;
    endfunction

    // expectation built from the requirements
    function automatic exp_t model(logic [31:0] a, logic rd, logic [1:0] sz, string tag);
        exp_t e;
        int   ncs = 0;
        int   ndr = 0;
        int   idx = 0;
        logic [7:0] cs_h = '0;
        logic [1:0] dr_h = '0;
        logic [1:0] ps;
        logic [3:0] ln;
        for (int i = 0; i < NR; i++) begin
            if (sh_valid[i] && ((a & ~sh_mask[i]) == (sh_base[i] & ~sh_mask[i]))) begin
                idx = i;
                if (i < 8) begin ncs++; cs_h[i] = 1'b1; end
                else begin ndr++; dr_h[i-8] = 1'b1; end
            end
        end
        e.tag  = tag;
        e.conf = (ndr == 2) || (ndr == 1 && ncs > 0);
        if (!e.conf && (ncs + ndr) == 1) begin
            ps      = (sh_ps[idx] == 2'b11) ? 2'b00 : sh_ps[idx];
            e.binh  = !sh_bur[idx];
            e.eterm = !sh_it[idx];
        end else begin
            ps = 2'b00; e.binh = 1'b1; e.eterm = 1'b1;
        end
        e.ps = ps;
        if (ps == 2'b01) ln = 4'b1000;
        else if (ps == 2'b10) ln = (sz == 2'b00) ? (a[0] ? 4'b0100 : 4'b1000) : 4'b1100;
        else if (sz == 2'b00) begin
            ln = '0; ln[3 - a[1:0]] = 1'b1;
        end else if (sz == 2'b01) ln = a[1] ? 4'b0011 : 4'b1100;
        else ln = 4'b1111;
        if (e.conf) begin
            e.cs_n = 8'hFF; e.dram = 2'b00; e.bs_n = 4'hF; e.oe_n = 1'b1;
        end else begin
            e.cs_n = ~cs_h; e.dram = dr_h; e.bs_n = ~ln; e.oe_n = !rd;
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        n_checks++;
        if (cs_n !== e.cs_n || dram_sel !== e.dram || bs_n !== e.bs_n || oe_n !== e.oe_n ||
            attr_psize !== e.ps || attr_burst_inh !== e.binh || attr_ext_term !== e.eterm ||
            conflict !== e.conf) begin
            n_fail++;
            $display("FAIL %s: got cs_n=%b dram=%b bs_n=%b oe_n=%b ps=%b binh=%b eterm=%b conf=%b exp cs_n=%b dram=%b bs_n=%b oe_n=%b ps=%b binh=%b eterm=%b conf=%b",
                     e.tag, cs_n, dram_sel, bs_n, oe_n, attr_psize, attr_burst_inh, attr_ext_term, conflict,
                     e.cs_n, e.dram, e.bs_n, e.oe_n, e.ps, e.binh, e.eterm, e.conf);
        end
    endtask

    task automatic write_region(int sel, logic [31:0] b, logic [31:0] m, logic v,
                                logic [1:0] ps, logic bur, logic it);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_base = b; cfg_mask = m;
        cfg_valid = v; cfg_psize = ps; cfg_burst_en = bur; cfg_int_term = it;
        if (sel < NR) begin
            sh_base[sel] = b; sh_mask[sel] = m; sh_valid[sel] = v;
            sh_ps[sel] = ps; sh_bur[sel] = bur; sh_it[sel] = it;
        end
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // driver: one full bus cycle, expectations pushed to the scoreboard
    task automatic run_cycle(logic [31:0] a, logic rd, logic [1:0] sz, string tag);
        exp_t e;
        e = model(a, rd, sz, tag);
        @(posedge clk); #1;
        cyc_addr = a; cyc_rd = rd; cyc_size = sz; cyc_start = 1'b1;
        q.push_back(e);
        @(posedge clk); #1;
        // R10 R11: new start and new address while active must change nothing
        cyc_addr = ~a; cyc_rd = !rd; cyc_size = ~sz; cyc_start = 1'b1;
        e.tag = {tag, " hold R10"};
        q.push_back(e);
        @(posedge clk); #1;
        cyc_start = 1'b0; cyc_end = 1'b1;
        @(negedge clk); #1;
        compare(idle_exp("R10 finish to idle"));
        @(posedge clk); #1;
        cyc_end = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            wait (q.size() > 0);
            @(negedge clk); #1;
            compare(q.pop_front());
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            sh_base[i] = '0; sh_mask[i] = '0; sh_valid[i] = 1'b0;
            sh_ps[i] = 2'b00; sh_bur[i] = 1'b0; sh_it[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        compare(idle_exp("R11 reset state"));

        write_region(0, 32'h1000_0000, 32'h00FF_FFFF, 1, 2'b00, 1, 1);
        write_region(1, 32'h2000_0000, 32'h00FF_FFFF, 1, 2'b10, 0, 1);
        write_region(2, 32'h2080_0000, 32'h007F_FFFF, 1, 2'b00, 1, 1);
        write_region(3, 32'h3000_0000, 32'h0000_0000, 0, 2'b00, 1, 1);
        write_region(4, 32'h4000_0000, 32'h0000_FFFF, 1, 2'b11, 1, 1);
        write_region(5, 32'h8100_0000, 32'h0000_FFFF, 1, 2'b10, 1, 1);
        write_region(6, 32'h6000_0000, 32'h0000_FFFF, 1, 2'b01, 0, 0);
        write_region(8, 32'h8000_0000, 32'h0FFF_FFFF, 1, 2'b00, 1, 1);
        write_region(9, 32'h8800_0000, 32'h00FF_FFFF, 1, 2'b10, 0, 0);
        write_region(15, 32'h5000_0000, 32'h0000_FFFF, 1, 2'b00, 1, 1);

        // R11: cyc_end while idle is ignored
        @(posedge clk); #1; cyc_end = 1'b1;
        @(negedge clk); #1;
        compare(idle_exp("R11 end while idle"));
        @(posedge clk); #1; cyc_end = 1'b0;

        run_cycle(32'h1000_0002, 1, 2'b00, "R2 R7 R9 byte read 32-bit port");
        run_cycle(32'h10AB_CDE0, 0, 2'b10, "R1 R7 R9 masked long write");
        run_cycle(32'h1000_0006, 1, 2'b01, "R7 upper-half word read");
        run_cycle(32'h2000_0001, 1, 2'b00, "R2 R8 16-bit port odd byte");
        run_cycle(32'h2000_0002, 0, 2'b10, "R8 16-bit port long");
        run_cycle(32'h2080_0003, 1, 2'b00, "R5 multiple chip selects");
        run_cycle(32'h6000_0002, 1, 2'b01, "R8 8-bit port word");
        run_cycle(32'h4000_1234, 0, 2'b00, "R12 reserved width code");
        run_cycle(32'h3000_0000, 1, 2'b10, "R1 R4 invalid region");
        run_cycle(32'h1100_0000, 1, 2'b00, "R1 R4 unmasked bit differs");
        run_cycle(32'h5000_0010, 1, 2'b10, "R12 R4 discarded write index");
        run_cycle(32'h8000_0100, 1, 2'b10, "R3 DRAM block 0");
        run_cycle(32'h8800_0004, 1, 2'b10, "R6 DRAM overlap");
        run_cycle(32'h8100_1234, 1, 2'b01, "R6 DRAM and chip select");

        write_region(8, 32'hA000_0000, 32'h0FFF_FFFF, 1, 2'b00, 1, 1);
        run_cycle(32'h8800_0002, 1, 2'b01, "R3 R12 DRAM block 1 after rewrite");
        run_cycle(32'h8100_0010, 0, 2'b00, "R2 R12 chip select after DRAM move");

        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule